// File: doc/BRIEF.md
# Self-Recovering Decimal Digit Counter

This block holds one decimal digit in four flip-flops and steps it once per enabled clock, from 0 up to 9 and then back to 0. A flag goes high while the digit shows 9, so a neighbour can see that the next enabled step will wrap. The successor of every one of the sixteen codes comes from a fixed set of XOR-form equations. Because of this, the six codes above 9 also have defined successors. If a disturbance leaves the digit in one of them, it returns to a decimal value after at most two enabled steps.

A synchronous, active-high reset clears the digit. A preset port loads any four-bit code, including an illegal one. It exists so that the recovery paths can be tested, and a parameter can remove it.

Top module: `bcd_decade_counter`

## Requirements
- R1: When `rst_i` is high at a rising edge, the digit becomes 0000 on that edge, whatever the other inputs do.
- R2: With reset and preset low and `cnt_en_i` high, a digit from 0 to 8 advances by one on each edge.
- R3: With the same controls, digit 9 (1001) is followed by 0 (0000).
- R4: `term_o` equals digit bit 0 AND digit bit 3, taken from the current digit. It is high for 9, 11, 13 and 15 and low for every other code, with or without the enable.
- R5: With reset, preset and `cnt_en_i` all low, the digit keeps its value across the edge.
- R6: Counting from a code above 9 gives these successors: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2.
- R7: From any code above 9, two counting edges in a row always reach a value from 0 to 9.
- R8: With reset low and `preset_en_i` high, the edge loads `preset_val_i` as the digit (bit 3 = the weight-8 bit), whatever `cnt_en_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset to 0000, active high, highest priority |
| cnt_en_i | input | 1 | Count enable; the digit holds when low |
| preset_en_i | input | 1 | Test load strobe, takes priority over counting |
| preset_val_i | input | 4 | Code loaded by the preset |
| digit_o | output | 4 | Current digit, bit 3 has weight 8 |
| term_o | output | 1 | Terminal-count flag, digit bit 0 AND bit 3 |

## Verification
The bench builds the counter with its default parameters, so the preset port is present. That port is the only way to reach the six codes above 9. Through it the bench places the digit in each illegal code, with the enable both high and low. It then follows the two counting edges that follow and checks each successor and the return to a decimal value. The normal wrap, the holds and a reset issued in the middle of a count are covered by the same scoreboard that tracks the flag.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t digit;
    } ctr_state_t;

    localparam digit_t DIGIT_ZERO = '0;
endpackage

// File: rtl/bcd_next_state.sv
module bcd_next_state
    import bcd_pkg::*;
(
    input  digit_t cur_i,
    output digit_t nxt_o
);
    logic w1, w2, w4, w8;

    always_comb begin
        w1 = cur_i[0];
        w2 = cur_i[1];
        w4 = cur_i[2];
        w8 = cur_i[3];
        nxt_o[0] = ~w1;
        nxt_o[1] = w2 ^ (w1 & ~w8);
        nxt_o[2] = w4 ^ (w1 & w2);
        nxt_o[3] = w8 ^ ((w1 & w8) | (w1 & w2 & w4));
    end
endmodule

// File: rtl/bcd_term_decode.sv
module bcd_term_decode
    import bcd_pkg::*;
(
    input  digit_t cur_i,
    output logic   term_o
);
    always_comb term_o = cur_i[0] & cur_i[DIGIT_W-1];
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_pkg::*;
#(
    parameter bit PRESET_EN = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               cnt_en_i,
    input  logic               preset_en_i,
    input  logic [DIGIT_W-1:0] preset_val_i,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               term_o
);
    ctr_state_t state_d, state_q;
    digit_t     step_val;
    logic       load_req;

    bcd_next_state u_next (
        .cur_i (state_q.digit),
        .nxt_o (step_val)
    );

    bcd_term_decode u_term (
        .cur_i  (state_q.digit),
        .term_o (term_o)
    );

    generate
        if (PRESET_EN) begin : g_preset
            assign load_req = preset_en_i;
        end else begin : g_no_preset
            logic unused_preset;
            assign unused_preset = preset_en_i;
            assign load_req      = 1'b0;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (rst_i) begin
            state_d.digit = DIGIT_ZERO;
        end else if (load_req) begin
            state_d.digit = preset_val_i;
        end else if (cnt_en_i) begin
            state_d.digit = step_val;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign digit_o = state_q.digit;
endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk
    import bcd_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic               cnt_en_i,
    input logic               preset_en_i,
    input logic [DIGIT_W-1:0] preset_val_i,
    input logic [DIGIT_W-1:0] digit_o,
    input logic               term_o
);
    logic step;
    assign step = !rst_i && !preset_en_i && cnt_en_i;

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        rst_i |=> digit_o == 4'd0);

    assert_count_up_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && digit_o < 4'd9) |=> digit_o == $past(digit_o) + 4'd1);

    assert_wrap_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && digit_o == 4'd9) |=> digit_o == 4'd0);

    assert_flag_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        term_o |-> (digit_o == 4'd9 || digit_o == 4'd11 ||
                    digit_o == 4'd13 || digit_o == 4'd15));

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!preset_en_i && !cnt_en_i) |=> $stable(digit_o));

    assert_illegal11_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && digit_o == 4'd11) |=> digit_o == 4'd6);

    assert_illegal15_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && digit_o == 4'd15) |=> digit_o == 4'd2);

    assert_recover_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && digit_o > 4'd9 && $past(step) && $past(digit_o) > 4'd9)
        |=> digit_o <= 4'd9);

    assert_preset_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        preset_en_i |=> digit_o == $past(preset_val_i));
endmodule

bind bcd_decade_counter bcd_decade_counter_chk chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .cnt_en_i     (cnt_en_i),
    .preset_en_i  (preset_en_i),
    .preset_val_i (preset_val_i),
    .digit_o      (digit_o),
    .term_o       (term_o)
);

// File: tb/bcd_decade_counter_tb_top.sv
module bcd_decade_counter_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       cnt_en_i = 1'b0;
    logic       preset_en_i = 1'b0;
    logic [3:0] preset_val_i = 4'd0;
    logic [3:0] digit_o;
    logic       term_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] mdl = 4'd0;

    typedef struct {
        logic [3:0] dig;
        logic       term;
        bit         legal;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk_i = ~clk_i;

    bcd_decade_counter dut_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .cnt_en_i     (cnt_en_i),
        .preset_en_i  (preset_en_i),
        .preset_val_i (preset_val_i),
        .digit_o      (digit_o),
        .term_o       (term_o)
    );

    function automatic logic [3:0] succ(input logic [3:0] v);
        case (v)
            4'd9:    return 4'd0;
            4'd10:   return 4'd11;
            4'd11:   return 4'd6;
            4'd12:   return 4'd13;
            4'd13:   return 4'd4;
            4'd14:   return 4'd15;
            4'd15:   return 4'd2;
            default: return v + 4'd1;
        endcase
    endfunction

    function automatic logic flag_of(input logic [3:0] v);
        return (v == 4'd9) || (v == 4'd11) || (v == 4'd13) || (v == 4'd15);
    endfunction

    task automatic drive(input logic r, input logic en, input logic pre,
                         input logic [3:0] val, input string tag, input bit legal);
        exp_t e;
        @(negedge clk_i);
        rst_i = r; cnt_en_i = en; preset_en_i = pre; preset_val_i = val;
        if (r)        mdl = 4'd0;
        else if (pre) mdl = val;
        else if (en)  mdl = succ(mdl);
        e.dig = mdl; e.term = flag_of(mdl); e.legal = legal; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk_i) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (digit_o !== e.dig) begin
                errors++;
                $display("FAIL %s digit actual=%0d expected=%0d", e.tag, digit_o, e.dig);
            end
            checks++;
            if (term_o !== e.term) begin
                errors++;
                $display("FAIL R4 flag actual=%0b expected=%0b digit=%0d", term_o, e.term, e.dig);
            end
            if (e.legal) begin
                checks++;
                if (digit_o > 4'd9) begin
                    errors++;
                    $display("FAIL R7 digit actual=%0d expected<=9", digit_o);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        drive(1, 1, 1, 4'd7, "R1", 0);
        for (int i = 0; i < 23; i++)
            drive(0, 1, 0, 4'd0, (mdl == 4'd9) ? "R3" : "R2", 0);
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 4'd0, "R5", 0);
        drive(0, 1, 0, 4'd0, "R2", 0);
        drive(1, 1, 0, 4'd0, "R1", 0);
        drive(0, 0, 1, 4'd9, "R8", 0);
        drive(0, 0, 0, 4'd0, "R5", 0);
        drive(0, 1, 0, 4'd0, "R3", 0);
        for (int c = 10; c < 16; c++) begin
            drive(0, c[0], 1, 4'(c), "R8", 0);
            drive(0, 0, 0, 4'd0, "R5", 0);
            drive(0, 1, 0, 4'd0, "R6", 0);
            drive(0, 1, 0, 4'd0, "R7", 1);
        end
        drive(0, 0, 1, 4'd13, "R8", 0);
        drive(1, 0, 1, 4'd5, "R1", 0);
        repeat (3) @(negedge clk_i);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule